// File: doc/BRIEF.md
# EEPROM Status Register and Write Protection Controller

This block keeps the status byte of a serial EEPROM: the write enable latch, the write-in-progress flag and three nonvolatile protection bits (a hardware-protect enable and a two-bit block protection code). It also decides, one event at a time, whether an array write or a status write may start. The serial front end decodes each instruction and hands this block a one-cycle event: enable-latch set, enable-latch clear, status write with its data byte, array write start with its address, or the end of a write cycle. The write-protect pin level comes straight in.

The block answers with a status byte for status reads, a one-cycle permit pulse for array writes and a one-cycle permit pulse for status writes. A write that is refused starts no cycle. When an array write is refused because its address lies in a protected block, or a status write is refused because of hardware protection, the enable latch still clears. The instruction has been taken, even though nothing is written.

At most one of the four instruction events is high in any cycle. The end-of-cycle event is independent of them and may come in the same cycle as any one of them.

Top module: `eeprom_wprot`

## Requirements
- R1: After synchronous reset, the status byte reads 0x00 and both permit outputs are low. The status byte layout is: bit 7 is the protect enable, bits 6:4 always read 0, bits 3:2 are the block code, bit 1 is the enable latch and bit 0 is write-in-progress.
- R2: An enable-set event makes bit 1 read 1 in the next cycle. An enable-clear event makes it read 0. Both act even while a write is in progress, and both act whatever the protection state is.
- R3: While bit 1 is 0, a status write or an array write has no effect: no permit pulse, and the status byte does not change.
- R4: Every status write or array write that is accepted clears bit 1 in the next cycle. A write is accepted when bit 1 is 1 and the block is not busy.
- R5: The block code chooses the protected addresses. Code 00 protects nothing. Code 01 protects addresses whose two top bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address. An accepted array write to a protected address gives no permit pulse and leaves bit 0 at 0.
- R6: An accepted array write to an unprotected address pulses the array permit for exactly one cycle, in the cycle after the event, and sets bit 0. Bit 0 returns to 0 in the cycle after the end-of-cycle event.
- R7: An accepted status write with no hardware protection loads bit 7 from data bit 7 and bits 3:2 from data bits 3:2, pulses the status permit, and sets bit 0. Data bits 6:4 and 1:0 are ignored.
- R8: Hardware protection is active when the pin is low and bit 7 is 1. An accepted status write under hardware protection changes bits 7 and 3:2 not at all, gives no pulse, and does not set bit 0, but it still clears bit 1. With the pin high, or with bit 7 at 0, the status write goes through.
- R9: Hardware protection has no effect on array writes.
- R10: While bit 0 is 1, a status write or array write that arrives without an end-of-cycle event in the same cycle is ignored completely, and bit 1 is kept.
- R11: A write that arrives in the same cycle as the end-of-cycle event is judged as if the block were idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_wren | input | 1 | Enable-latch set event |
| ev_wrdi | input | 1 | Enable-latch clear event |
| ev_wrsr | input | 1 | Status write event |
| wrsr_data | input | 8 | Data byte of the status write |
| ev_write | input | 1 | Array write start event |
| wr_addr | input | ADDR_W | Start address of the array write |
| ev_done | input | 1 | End of the current write cycle |
| wp_level | input | 1 | Write-protect pin level (low means protect) |
| status_byte | output | 8 | Status byte for status reads |
| array_wr_ok | output | 1 | One-cycle permit for an array write |
| status_wr_ok | output | 1 | One-cycle permit for a status write |

## Verification
The interesting overlap is the end of a write cycle landing in the same cycle as a new write event. In that case the write has to be judged against the freed state, not the busy one. The bench produces this overlap directly: it issues an array write together with the end-of-cycle event. It also produces it at random, by raising the end-of-cycle event on about a third of the busy cycles while instruction events keep coming. A reference model in the bench computes the permit pulses and the next status byte with the same same-cycle rule. It also covers the case where an enable-set event is taken in the middle of a busy cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  // Bit positions inside the status byte
  localparam int SB_PEN = 7;
  localparam int SB_BPH = 3;
  localparam int SB_BPL = 2;
  localparam int SB_WEL = 1;
  localparam int SB_WIP = 0;

  typedef enum logic [1:0] {
    BLK_NONE    = 2'b00,
    BLK_QUARTER = 2'b01,
    BLK_HALF    = 2'b10,
    BLK_ALL     = 2'b11
  } blk_code_t;
endpackage

// File: rtl/wp_block_decode.sv
module wp_block_decode
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  blk_code_t         code,
  output logic              is_locked
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] top2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = addr[TOP -: 2];
    end else begin : g_narrow
      assign top2 = {addr[TOP], addr[TOP]};
    end
  endgenerate

  always_comb begin
    unique case (code)
      BLK_NONE:    is_locked = 1'b0;
      BLK_QUARTER: is_locked = (top2 == 2'b11);
      BLK_HALF:    is_locked = top2[1];
      BLK_ALL:     is_locked = 1'b1;
      default:     is_locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic wel
);
  always_ff @(posedge clk) begin
    if (rst)          wel <= 1'b0;
    else if (clr_req) wel <= 1'b0;
    else if (set_req) wel <= 1'b1;
  end
endmodule

// File: rtl/wp_cycle_tracker.sv
module wp_cycle_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic wip
);
  always_ff @(posedge clk) begin
    if (rst)       wip <= 1'b0;
    else if (start) wip <= 1'b1;
    else if (done)  wip <= 1'b0;
  end
endmodule

// File: rtl/eeprom_wprot.sv
module eeprom_wprot
  import wprot_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter logic [2:0] NV_RESET = 3'b000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              ev_write,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              ev_done,
  input  logic              wp_level,
  output logic [7:0]        status_byte,
  output logic              array_wr_ok,
  output logic              status_wr_ok
);
  localparam int NV_W = 3;

  logic      wel_q, wip_q;
  logic      pen_q;
  blk_code_t blk_q;
  logic      busy, hw_lock, addr_locked;
  logic      take_wrsr, take_write, sr_go, arr_go;
  logic      unused_bits;

  // A completion in the same cycle frees the block for a new write (R11)
  assign busy       = wip_q & ~ev_done;
  assign hw_lock    = ~wp_level & pen_q;
  assign take_wrsr  = ev_wrsr  & wel_q & ~busy;
  assign take_write = ev_write & wel_q & ~busy;
  assign sr_go      = take_wrsr & ~hw_lock;
  assign arr_go     = take_write & ~addr_locked;
  assign unused_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

  wp_block_decode #(.ADDR_W(ADDR_W)) blk_dec_i (
    .addr      (wr_addr),
    .code      (blk_q),
    .is_locked (addr_locked)
  );

  wp_enable_latch wel_i (
    .clk     (clk),
    .rst     (rst),
    .set_req (ev_wren),
    .clr_req (ev_wrdi | take_wrsr | take_write),
    .wel     (wel_q)
  );

  wp_cycle_tracker wip_i (
    .clk   (clk),
    .rst   (rst),
    .start (sr_go | arr_go),
    .done  (ev_done),
    .wip   (wip_q)
  );

  // Nonvolatile protection bits
  always_ff @(posedge clk) begin
    if (rst) begin
      {pen_q, blk_q} <= NV_RESET[NV_W-1:0];
    end else if (sr_go) begin
      pen_q <= wrsr_data[SB_PEN];
      blk_q <= blk_code_t'(wrsr_data[SB_BPH:SB_BPL]);
    end
  end

  // Registered permit pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      array_wr_ok  <= 1'b0;
      status_wr_ok <= 1'b0;
    end else begin
      array_wr_ok  <= arr_go;
      status_wr_ok <= sr_go;
    end
  end

  always_comb begin
    status_byte         = 8'h00;
    status_byte[SB_PEN] = pen_q;
    status_byte[SB_BPH:SB_BPL] = blk_q;
    status_byte[SB_WEL] = wel_q;
    status_byte[SB_WIP] = wip_q;
  end
endmodule

// File: rtl/eeprom_wprot_chk.sv
module eeprom_wprot_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_wren,
  input logic       ev_wrdi,
  input logic       ev_wrsr,
  input logic       ev_write,
  input logic       ev_done,
  input logic       wp_level,
  input logic [7:0] status_byte,
  input logic       array_wr_ok,
  input logic       status_wr_ok
);
  assert_set_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_wren && !ev_wrdi) |=> status_byte[1]);

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ((ev_write || ev_wrsr) && status_byte[1] && !status_byte[0] && !ev_wren && !ev_wrdi)
      |=> !status_byte[1]);

  assert_all_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_write && status_byte[3:2] == 2'b11) |=> !array_wr_ok);

  assert_array_busy_R6: assert property (@(posedge clk) disable iff (rst)
    array_wr_ok |-> status_byte[0]);

  assert_wip_ends_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(status_byte[0]) |-> $past(ev_done));

  assert_status_busy_R7: assert property (@(posedge clk) disable iff (rst)
    status_wr_ok |-> status_byte[0]);

  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_wrsr && !wp_level && status_byte[7]) |=> (!status_wr_ok && $stable(status_byte[7])));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (status_byte[0] && !ev_done && (ev_write || ev_wrsr))
      |=> (!array_wr_ok && !status_wr_ok));
endmodule

bind eeprom_wprot eeprom_wprot_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .ev_wren      (ev_wren),
  .ev_wrdi      (ev_wrdi),
  .ev_wrsr      (ev_wrsr),
  .ev_write     (ev_write),
  .ev_done      (ev_done),
  .wp_level     (wp_level),
  .status_byte  (status_byte),
  .array_wr_ok  (array_wr_ok),
  .status_wr_ok (status_wr_ok)
);

// File: tb/eeprom_wprot_tb_top.sv
`timescale 1ns/1ps
module eeprom_wprot_tb_top;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_wren = 0, ev_wrdi = 0, ev_wrsr = 0, ev_write = 0, ev_done = 0;
  logic [7:0]    wrsr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic          wp_level = 1'b1;
  logic [7:0]    status_byte;
  logic          array_wr_ok, status_wr_ok;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  logic       m_wel = 0, m_wip = 0, m_pen = 0;
  logic [1:0] m_bp = 2'b00;

  always #4 clk = ~clk;

  eeprom_wprot #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_data(wrsr_data), .ev_write(ev_write),
    .wr_addr(wr_addr), .ev_done(ev_done), .wp_level(wp_level),
    .status_byte(status_byte), .array_wr_ok(array_wr_ok),
    .status_wr_ok(status_wr_ok)
  );

  function automatic logic locked(input logic [AW-1:0] a, input logic [1:0] bp);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_pen, 3'b000, m_bp, m_wel, m_wip};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // op: 0 idle, 1 set latch, 2 clear latch, 3 status write, 4 array write
  task automatic step(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic wp, input logic dn, input string tag);
    logic busy, ea, es;
    ev_wren  = (op == 1);
    ev_wrdi  = (op == 2);
    ev_wrsr  = (op == 3);
    ev_write = (op == 4);
    ev_done  = dn;
    wr_addr  = a;
    wrsr_data = d;
    wp_level = wp;
    busy = m_wip & ~dn;
    ea = 1'b0;
    es = 1'b0;
    case (op)
      1: m_wel = 1'b1;
      2: m_wel = 1'b0;
      3: if (m_wel && !busy) begin
           m_wel = 1'b0;
           if (wp || !m_pen) begin
             m_pen = d[7];
             m_bp  = d[3:2];
             es = 1'b1;
           end
         end
      4: if (m_wel && !busy) begin
           m_wel = 1'b0;
           if (!locked(a, m_bp)) ea = 1'b1;
         end
      default: ;
    endcase
    if (ea || es) m_wip = 1'b1;
    else if (dn)  m_wip = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(status_byte, exp_status(), tag, "status_byte");
    check({7'd0, array_wr_ok}, {7'd0, ea}, tag, "array_wr_ok");
    check({7'd0, status_wr_ok}, {7'd0, es}, tag, "status_wr_ok");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status_byte, 8'h00, "R1", "status_byte");
    check({7'd0, array_wr_ok}, 8'h00, "R1", "array_wr_ok");
    check({7'd0, status_wr_ok}, 8'h00, "R1", "status_wr_ok");

    step(4, 11'h010, 8'h00, 1, 0, "R3");          // array write without latch
    step(3, '0, 8'h8C, 1, 0, "R3");               // status write without latch
    step(1, '0, 8'h00, 1, 0, "R2");
    step(2, '0, 8'h00, 1, 0, "R2");
    step(1, '0, 8'h00, 1, 0, "R2");
    step(4, 11'h005, 8'h00, 1, 0, "R6");          // accepted, clears latch (R4)
    step(1, '0, 8'h00, 1, 0, "R2");               // latch set while busy
    step(4, 11'h006, 8'h00, 1, 0, "R10");         // dropped, latch kept
    step(3, '0, 8'h0C, 1, 0, "R10");
    step(4, 11'h007, 8'h00, 1, 1, "R11");         // write with completion
    step(0, '0, 8'h00, 1, 1, "R6");
    step(1, '0, 8'h00, 1, 0, "R2");
    step(3, '0, 8'h77, 1, 0, "R7");               // code 01, pen 0, junk bits
    step(0, '0, 8'h00, 1, 1, "R6");
    step(1, '0, 8'h00, 1, 0, "R2");
    step(4, 11'h7FF, 8'h00, 1, 0, "R5");          // top quarter locked
    step(1, '0, 8'h00, 1, 0, "R2");
    step(4, 11'h5FF, 8'h00, 1, 0, "R5");          // below quarter open
    step(0, '0, 8'h00, 1, 1, "R6");
    step(1, '0, 8'h00, 1, 0, "R2");
    step(3, '0, 8'h88, 1, 0, "R7");               // pen 1, code 10
    step(0, '0, 8'h00, 1, 1, "R6");
    step(1, '0, 8'h00, 0, 0, "R2");
    step(3, '0, 8'h00, 0, 0, "R8");               // locked by pin
    step(1, '0, 8'h00, 0, 0, "R2");
    step(4, 11'h100, 8'h00, 0, 0, "R9");          // array open under pin low
    step(0, '0, 8'h00, 0, 1, "R6");
    step(1, '0, 8'h00, 0, 0, "R2");
    step(4, 11'h400, 8'h00, 0, 0, "R5");          // upper half locked
    step(1, '0, 8'h00, 1, 0, "R2");
    step(3, '0, 8'h0C, 1, 0, "R8");               // pin high lets it through
    step(0, '0, 8'h00, 1, 1, "R6");
    step(1, '0, 8'h00, 1, 0, "R2");
    step(4, 11'h000, 8'h00, 1, 0, "R5");          // everything locked

    for (int i = 0; i < 4000; i++) begin
      int op;
      string tg;
      op = $urandom % 5;
      if (op == 0)      tg = "R6";
      else if (op < 3)  tg = "R2";
      else if (op == 3) tg = "R7";
      else              tg = "R5";
      step(op, AW'($urandom), 8'($urandom), 1'($urandom), m_wip && ($urandom % 3 == 0), tg);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule